// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Port

A full-duplex asynchronous serial port reached through a simple word-indexed read/write strobe bus. Software pushes transmit characters and pops received characters through one shared data register. A flags register shows FIFO and transmitter state. A status register reports the error bits of the character that was popped most recently. The line format and bit rate come from a staged divisor (a low and a mid register) and a line-control register. Writing the line-control register copies the staged divisor and the new line settings into the live baud generator and framing logic in the same cycle, so a three-register update takes effect all at once.

Transmitter and receiver both run from a shared tick at 16 times the bit rate. The receiver rejects short start pulses and samples each bit at its centre. Each received character is stored together with three status bits. Two level-sensitive interrupt outputs signal that receive data is waiting and that the transmit queue has room. Each queue holds 16 characters, or a single character when the FIFOs are disabled.

Register index (`addr_i`): 0 data, 1 receive status, 2 flags, 3 divisor low, 4 divisor mid, 5 line control.

Top module: `mmio_uart`

## Requirements
- R1: After reset, `tx_o` is high, the flags register reads 0x10 (receive empty), `rx_irq_o` is 0 and `tx_irq_o` is 1.
- R2: One bit lasts 16*(D+1) clock cycles. D is the 12-bit divisor: D[7:0] sits in register 3 bits 7:0 and D[11:8] sits in register 4 bits 3:0.
- R3: Writing registers 3 and 4 does not change the live bit rate. A write to register 5 loads the staged divisor and the line settings together.
- R4: A transmitted frame is a low start bit, then the data bits LSB first, then an optional parity bit, then one or two high stop bits. Line-control bits 6:5 set the word length (00=5, 01=6, 10=7, 11=8). Bit 1 enables parity, bit 2 selects even parity when set (odd when clear), and bit 3 selects two stop bits.
- R5: Line-control bit 0 forces `tx_o` low. Clearing it returns the idle line to high.
- R6: Flags bit 4 is set while receive data is absent, bit 5 is set while the transmit queue is full, and bit 3 is set while a character is queued or being shifted out.
- R7: A read of register 0 returns the oldest received character and removes it from the queue. Register 1 then reads that character's status: bit 0 framing error, bit 1 parity error, bit 2 overrun.
- R8: With parity enabled, a received parity bit that does not match the selected parity sets status bit 1.
- R9: A received stop bit sampled low sets status bit 0.
- R10: If a character completes while the receive queue is full, that character is discarded. The next character stored afterwards carries status bit 2.
- R11: A low pulse on `rx_i` shorter than half a bit time produces no character.
- R12: Line-control bit 4 enables 16-entry FIFOs, which keep characters in arrival order. With the bit clear, each direction holds a single character.
- R13: `rx_irq_o` is high while receive data is waiting. `tx_irq_o` is high while the transmit queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, also the oversampling reference |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (pops data at index 0) |
| addr_i | input | 3 | Register index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| rx_irq_o | output | 1 | Receive data waiting |
| tx_irq_o | output | 1 | Transmit queue has room |

## Verification
The bench uses the default parameters: a 16-entry FIFO and a 12-bit divisor. Most scenarios run with a live divisor of 0, which gives 16-cycle bits, so every frame format, error case and glitch can be reached in a few hundred cycles. Divisors of 3 and 0x100 check the scaling and the mid-register field, and filling the 16-entry transmit queue shows the full flag and the interrupt edge.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam logic [2:0] ADDR_DATA  = 3'd0;
  localparam logic [2:0] ADDR_STAT  = 3'd1;
  localparam logic [2:0] ADDR_FLAGS = 3'd2;
  localparam logic [2:0] ADDR_DIVLO = 3'd3;
  localparam logic [2:0] ADDR_DIVMD = 3'd4;
  localparam logic [2:0] ADDR_LCR   = 3'd5;

  typedef struct packed {
    logic [1:0] wlen;
    logic       fifo_en;
    logic       two_stop;
    logic       par_even;
    logic       par_en;
    logic       brk;
  } lcr_t;

  function automatic logic [7:0] word_mask(logic [1:0] w);
    return 8'hFF >> (2'd3 - w);
  endfunction

  function automatic logic [2:0] last_idx(logic [1:0] w);
    return 3'd4 + {1'b0, w};
  endfunction
endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  assign tick_o = (cnt_q >= div_i);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
endmodule

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = en_i ? (cnt_q == CW'(DEPTH)) : !empty_o;
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end

  always_ff @(posedge clk_i)
    if (do_push) mem_q[wp_q] <= wdata_i;
endmodule

// File: rtl/uart_tx.sv
module uart_tx import uart_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  lcr_t       cfg_i,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  output logic       pop_o,
  output logic       tx_o,
  output logic       busy_o
);
  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tstate_e;
  tstate_e    st_q;
  logic [3:0] cnt_q;
  logic [2:0] idx_q;
  logic       stop2_q;
  logic [7:0] hold_q;
  logic       pbit, line;

  assign pop_o  = (st_q == T_IDLE) && valid_i;
  assign busy_o = (st_q != T_IDLE);
  assign pbit   = cfg_i.par_even ? ^(hold_q & word_mask(cfg_i.wlen))
                                 : ~^(hold_q & word_mask(cfg_i.wlen));

  always_comb
    case (st_q)
      T_START: line = 1'b0;
      T_DATA:  line = hold_q[idx_q];
      T_PAR:   line = pbit;
      default: line = 1'b1;
    endcase

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q <= T_IDLE; cnt_q <= '0; idx_q <= '0; stop2_q <= 1'b0;
      hold_q <= '0; tx_o <= 1'b1;
    end else begin
      tx_o <= cfg_i.brk ? 1'b0 : line;
      if (st_q == T_IDLE) begin
        if (valid_i) begin
          hold_q <= data_i; st_q <= T_START; cnt_q <= '0; idx_q <= '0;
        end
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == 4'd15)
          case (st_q)
            T_START: st_q <= T_DATA;
            T_DATA: begin
              if (idx_q == last_idx(cfg_i.wlen)) begin
                st_q <= cfg_i.par_en ? T_PAR : T_STOP; stop2_q <= 1'b0;
              end else idx_q <= idx_q + 1'b1;
            end
            T_PAR: begin st_q <= T_STOP; stop2_q <= 1'b0; end
            default: begin
              if (cfg_i.two_stop && !stop2_q) stop2_q <= 1'b1;
              else st_q <= T_IDLE;
            end
          endcase
      end
    end
endmodule

// File: rtl/uart_rx.sv
module uart_rx import uart_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  lcr_t       cfg_i,
  input  logic       rx_i,
  output logic       push_o,
  output logic [7:0] data_o,
  output logic       ferr_o,
  output logic       perr_o
);
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rstate_e;
  rstate_e    st_q;
  logic [1:0] sync_q;
  logic       rx_s;
  logic [3:0] cnt_q;
  logic [2:0] idx_q;
  logic [7:0] sh_q;
  logic       pbit_q, exp_par;

  assign rx_s    = sync_q[1];
  assign exp_par = cfg_i.par_even ? ^(sh_q & word_mask(cfg_i.wlen))
                                  : ~^(sh_q & word_mask(cfg_i.wlen));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sync_q <= 2'b11; st_q <= R_IDLE; cnt_q <= '0; idx_q <= '0; sh_q <= '0;
      pbit_q <= 1'b0; push_o <= 1'b0; data_o <= '0; ferr_o <= 1'b0; perr_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      push_o <= 1'b0;
      if (st_q == R_IDLE) begin
        if (!rx_s) begin st_q <= R_START; cnt_q <= '0; end
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
        case (st_q)
          R_START:
            if (cnt_q == 4'd7) begin
              // half-bit qualification of the start edge
              if (!rx_s) begin st_q <= R_DATA; cnt_q <= '0; idx_q <= '0; sh_q <= '0; end
              else st_q <= R_IDLE;
            end
          R_DATA:
            if (cnt_q == 4'd15) begin
              sh_q[idx_q] <= rx_s;
              if (idx_q == last_idx(cfg_i.wlen)) st_q <= cfg_i.par_en ? R_PAR : R_STOP;
              else idx_q <= idx_q + 1'b1;
            end
          R_PAR:
            if (cnt_q == 4'd15) begin pbit_q <= rx_s; st_q <= R_STOP; end
          default:
            if (cnt_q == 4'd15) begin
              push_o <= 1'b1;
              data_o <= sh_q;
              ferr_o <= !rx_s;
              perr_o <= cfg_i.par_en && (pbit_q != exp_par);
              st_q   <= R_IDLE;
            end
        endcase
      end
    end
endmodule

// File: rtl/mmio_uart.sv
module mmio_uart import uart_pkg::*; #(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        rx_i,
  output logic        tx_o,
  output logic        rx_irq_o,
  output logic        tx_irq_o
);
  localparam int MID_W = DIV_W - 8;
  localparam int LCR_W = $bits(lcr_t);

  logic [7:0]       div_lo_q;
  logic [MID_W-1:0] div_md_q;
  logic [DIV_W-1:0] div_act_q;
  lcr_t             lcr_q;
  logic [2:0]       rx_stat_q;
  logic             ovr_pend_q;

  logic tick, tx_full, tx_empty, tx_pop, tx_busy, tx_valid;
  logic [7:0] tx_head;
  logic rx_push, rx_full, rx_empty, rx_pop, ferr, perr;
  logic [7:0] rx_byte;
  logic [10:0] rx_head;
  logic wr_data, busy;

  assign wr_data  = wr_i && (addr_i == ADDR_DATA);
  assign rx_pop   = rd_i && (addr_i == ADDR_DATA) && !rx_empty;
  assign tx_valid = !tx_empty;
  assign busy     = tx_busy || !tx_empty;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      div_lo_q <= '0; div_md_q <= '0; div_act_q <= '0; lcr_q <= '0;
      rx_stat_q <= '0; ovr_pend_q <= 1'b0;
    end else begin
      if (wr_i && addr_i == ADDR_DIVLO) div_lo_q <= wdata_i[7:0];
      if (wr_i && addr_i == ADDR_DIVMD) div_md_q <= wdata_i[MID_W-1:0];
      if (wr_i && addr_i == ADDR_LCR) begin
        div_act_q <= {div_md_q, div_lo_q};
        lcr_q     <= lcr_t'(wdata_i[LCR_W-1:0]);
      end
      if (rx_pop) rx_stat_q <= rx_head[10:8];
      if (rx_push) ovr_pend_q <= rx_full;
    end

  uart_baud #(.DIV_W(DIV_W)) i_baud (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_act_q), .tick_o(tick));

  uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) i_txf (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(lcr_q.fifo_en), .push_i(wr_data),
    .wdata_i(wdata_i[7:0]), .pop_i(tx_pop), .rdata_o(tx_head),
    .empty_o(tx_empty), .full_o(tx_full));

  uart_tx i_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .cfg_i(lcr_q),
    .valid_i(tx_valid), .data_i(tx_head), .pop_o(tx_pop), .tx_o(tx_o),
    .busy_o(tx_busy));

  uart_rx i_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .cfg_i(lcr_q), .rx_i(rx_i),
    .push_o(rx_push), .data_o(rx_byte), .ferr_o(ferr), .perr_o(perr));

  uart_fifo #(.W(11), .DEPTH(FIFO_DEPTH)) i_rxf (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(lcr_q.fifo_en), .push_i(rx_push),
    .wdata_i({ovr_pend_q, perr, ferr, rx_byte}), .pop_i(rx_pop),
    .rdata_o(rx_head), .empty_o(rx_empty), .full_o(rx_full));

  assign rx_irq_o = !rx_empty;
  assign tx_irq_o = !tx_full;

  always_comb
    case (addr_i)
      ADDR_DATA:  rdata_o = {24'b0, rx_head[7:0]};
      ADDR_STAT:  rdata_o = {29'b0, rx_stat_q};
      ADDR_FLAGS: rdata_o = {26'b0, tx_full, rx_empty, busy, 3'b0};
      ADDR_DIVLO: rdata_o = 32'(div_lo_q);
      ADDR_DIVMD: rdata_o = 32'(div_md_q);
      ADDR_LCR:   rdata_o = 32'(lcr_q);
      default:    rdata_o = '0;
    endcase
endmodule

// File: rtl/mmio_uart_checker.sv
module mmio_uart_checker #(
  parameter int DIV_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic [2:0]       addr_i,
  input logic             tx_o,
  input logic             brk,
  input logic             tx_busy,
  input logic [DIV_W-1:0] div_act,
  input logic             rx_push,
  input logic             rx_full,
  input logic             ovr_pend
);
  AST_BREAK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk |=> !tx_o); // R5
  AST_IDLE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_busy && !brk) |=> tx_o); // R4
  AST_STOP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(tx_busy) && !brk && !$past(brk)) |-> tx_o); // R4
  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == 3'd5) |=> $stable(div_act)); // R3
  AST_OVR_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push && rx_full) |=> ovr_pend); // R10
endmodule

bind mmio_uart mmio_uart_checker #(.DIV_W(DIV_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .tx_o(tx_o),
  .brk(lcr_q.brk), .tx_busy(tx_busy), .div_act(div_act_q), .rx_push(rx_push),
  .rx_full(rx_full), .ovr_pend(ovr_pend_q));

// File: tb/test_mmio_uart.sv
module test_mmio_uart;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0, rx = 1'b1;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic tx, rx_irq, tx_irq;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  mmio_uart i_mmio_uart (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_i(rx), .tx_o(tx),
    .rx_irq_o(rx_irq), .tx_irq_o(tx_irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a; #1 d = rdata;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic set_line(logic [6:0] lcr);
    wr_reg(3'd3, 32'd0); wr_reg(3'd4, 32'd0); wr_reg(3'd5, {25'b0, lcr});
  endtask

  // drive one frame into rx_i, bit time 16 cycles
  task automatic send_rx(logic [7:0] d, int nbits, int par, bit even, int stop_low);
    bit p;
    p = even ? ^(d & ((8'd1 << nbits) - 1)) : ~^(d & ((8'd1 << nbits) - 1));
    @(negedge clk); rx = 1'b0; repeat (16) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin rx = d[i]; repeat (16) @(negedge clk); end
    if (par != 0) begin rx = (par == 2) ? ~p : p; repeat (16) @(negedge clk); end
    if (stop_low != 0) begin rx = 1'b0; repeat (13) @(negedge clk); end
    rx = 1'b1; repeat (20) @(negedge clk);
  endtask

  // decode one transmitted frame at 16 cycles per bit
  task automatic cap_tx(int nbits, bit par, output logic [7:0] d, output logic pb,
                        output logic s1, output logic s2, output logic bsy);
    d = '0; pb = 1'b0;
    addr = 3'd2;
    while (tx !== 1'b0) @(negedge clk);
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin repeat (16) @(negedge clk); d[i] = tx; end
    if (par) begin repeat (16) @(negedge clk); pb = tx; end
    repeat (16) @(negedge clk); s1 = tx;
    repeat (16) @(negedge clk); s2 = tx; #1 bsy = rdata[3];
  endtask

  task automatic high_len(output int n);
    n = 0;
    while (tx !== 1'b0) @(negedge clk);
    while (tx !== 1'b1) @(negedge clk);
    while (tx === 1'b1) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 tx idle", {31'b0, tx}, 1);
    check("R1 rx_irq", {31'b0, rx_irq}, 0);
    check("R1 tx_irq", {31'b0, tx_irq}, 1);
    rd_reg(3'd2, v); check("R1 flags", v, 32'h10);
  endtask

  task automatic t_tx_formats;
    logic [7:0] d; logic pb, s1, s2, b;
    set_line(7'h60);
    wr_reg(3'd0, 32'hA5);
    cap_tx(8, 1'b0, d, pb, s1, s2, b);
    check("R4 8N1 data", {24'b0, d}, 32'hA5);
    check("R4 8N1 stop", {31'b0, s1}, 1);
    check("R6 busy clear after one stop", {31'b0, b}, 0);
    set_line(7'h4E);
    wr_reg(3'd0, 32'h5B);
    cap_tx(7, 1'b1, d, pb, s1, s2, b);
    check("R4 7E2 data", {24'b0, d}, 32'h5B);
    check("R4 7E2 even parity", {31'b0, pb}, 1);
    check("R4 7E2 stop2", {30'b0, s1, s2}, 3);
    check("R6 busy during second stop", {31'b0, b}, 1);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_divisor;
    int n;
    set_line(7'h60);
    wr_reg(3'd3, 32'd3);
    wr_reg(3'd0, 32'h01); high_len(n);
    check("R3 staged divisor not live", n, 16);
    repeat (200) @(negedge clk);
    wr_reg(3'd5, 32'h60);
    wr_reg(3'd0, 32'h01); high_len(n);
    check("R2 divisor 3", n, 64);
    repeat (800) @(negedge clk);
    wr_reg(3'd3, 32'd0); wr_reg(3'd4, 32'd1); wr_reg(3'd5, 32'h60);
    wr_reg(3'd0, 32'h01); high_len(n);
    check("R2 mid field divisor 0x100", n, 16 * 257);
    repeat (16 * 257 * 8) @(negedge clk);
    set_line(7'h60);
  endtask

  task automatic t_break;
    wr_reg(3'd5, 32'h61); repeat (3) @(negedge clk);
    check("R5 break low", {31'b0, tx}, 0);
    wr_reg(3'd5, 32'h60); repeat (3) @(negedge clk);
    check("R5 break released", {31'b0, tx}, 1);
  endtask

  task automatic t_rx_basic;
    logic [31:0] v;
    set_line(7'h60);
    send_rx(8'h3C, 8, 0, 1'b0, 0);
    check("R13 rx_irq set", {31'b0, rx_irq}, 1);
    rd_reg(3'd2, v); check("R6 rx not empty", {31'b0, v[4]}, 0);
    rd_reg(3'd0, v); check("R7 rx data", v, 32'h3C);
    rd_reg(3'd1, v); check("R7 clean status", v, 0);
    rd_reg(3'd2, v); check("R6 rx empty after pop", {31'b0, v[4]}, 1);
    check("R13 rx_irq cleared", {31'b0, rx_irq}, 0);
  endtask

  task automatic t_rx_errors;
    logic [31:0] v;
    set_line(7'h66);
    send_rx(8'h3C, 8, 2, 1'b1, 0);
    rd_reg(3'd0, v); check("R8 data with bad parity", v, 32'h3C);
    rd_reg(3'd1, v); check("R8 parity error", v, 32'h2);
    send_rx(8'h3D, 8, 1, 1'b1, 0);
    rd_reg(3'd0, v); rd_reg(3'd1, v); check("R8 good parity", v, 0);
    set_line(7'h60);
    send_rx(8'h81, 8, 0, 1'b0, 1);
    rd_reg(3'd0, v); check("R9 data", v, 32'h81);
    rd_reg(3'd1, v); check("R9 framing error", v, 32'h1);
    rd_reg(3'd2, v); check("R11 no phantom after low stop", {31'b0, v[4]}, 1);
    set_line(7'h00);
    send_rx(8'h15, 5, 0, 1'b0, 0);
    rd_reg(3'd0, v); check("R4 five-bit receive", v, 32'h15);
  endtask

  task automatic t_overrun;
    logic [31:0] v;
    set_line(7'h60);
    send_rx(8'h11, 8, 0, 1'b0, 0);
    send_rx(8'h22, 8, 0, 1'b0, 0);
    rd_reg(3'd0, v); check("R10 first kept", v, 32'h11);
    rd_reg(3'd1, v); check("R10 first status", v, 0);
    rd_reg(3'd2, v); check("R10 second discarded", {31'b0, v[4]}, 1);
    send_rx(8'h33, 8, 0, 1'b0, 0);
    rd_reg(3'd0, v); check("R10 next data", v, 32'h33);
    rd_reg(3'd1, v); check("R10 overrun flag", v, 32'h4);
  endtask

  task automatic t_glitch;
    logic [31:0] v;
    @(negedge clk); rx = 1'b0; repeat (4) @(negedge clk); rx = 1'b1;
    repeat (200) @(negedge clk);
    rd_reg(3'd2, v); check("R11 glitch rejected", {31'b0, v[4]}, 1);
    check("R11 no rx_irq", {31'b0, rx_irq}, 0);
  endtask

  task automatic t_fifo;
    logic [31:0] v;
    set_line(7'h70);
    send_rx(8'hA1, 8, 0, 1'b0, 0);
    send_rx(8'hB2, 8, 0, 1'b0, 0);
    send_rx(8'hC3, 8, 0, 1'b0, 0);
    rd_reg(3'd0, v); check("R12 rx order 0", v, 32'hA1);
    rd_reg(3'd0, v); check("R12 rx order 1", v, 32'hB2);
    rd_reg(3'd0, v); check("R12 rx order 2", v, 32'hC3);
    rd_reg(3'd1, v); check("R12 no overrun with fifo", v, 0);
    for (int i = 0; i < 16; i++) wr_reg(3'd0, 32'(i));
    check("R13 tx_irq with room", {31'b0, tx_irq}, 1);
    wr_reg(3'd0, 32'h10);
    rd_reg(3'd2, v); check("R6 tx full flag", {31'b0, v[5]}, 1);
    check("R13 tx_irq low when full", {31'b0, tx_irq}, 0);
    for (int i = 0; i < 17 * 10 * 16 + 100; i++) @(negedge clk);
    rd_reg(3'd2, v); check("R12 drained", v, 32'h10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_tx_formats;
    t_divisor;
    t_break;
    t_rx_basic;
    t_rx_errors;
    t_overrun;
    t_glitch;
    t_fifo;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule